// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a synchronous DRAM read or write burst. A controller gives it a start column, a 3-bit burst-length code and a beat-order select, then pulses the start input for one cycle. From the next clock on, the block shows one column per clock, flagging each valid beat and marking the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned window that holds the start column. The beat order inside that window is either counting upward with wrap-around or the start bits XORed with the beat number. A full-page burst walks the whole 256-column page upward, wraps past the top and runs until a stop request arrives. A new start pulse takes over at once from a running burst. A clock-enable input freezes the whole block while it is low. Command decoding, DRAM timing and the data path belong to other blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: A start pulse sampled with clock enable high makes the next cycle show beat valid high with the column equal to the sampled start column.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of exactly 1, 2, 4 and 8 valid beats.
- R3: With the order select low (sequential), beat i of a fixed burst of length L has its low log2(L) bits equal to (start + i) mod L, and its upper column bits equal to those of the start column.
- R4: With the order select high (interleaved), beat i of a fixed burst of length L has its low log2(L) bits equal to the start's low bits XOR i, and its upper bits equal to those of the start column.
- R5: Length code 3'b111 selects full page. The column counts upward from the start whatever the order select is, wraps from 255 to 0, continues until stopped, and never raises the last-beat flag.
- R6: The last-beat flag is high exactly on the final beat of a fixed-length burst and only while beat valid is high. When no new start comes, beat valid is low on the following cycle.
- R7: A stop request sampled with clock enable high and no start pulse makes beat valid low on the next cycle, for both fixed and full-page bursts.
- R8: A start pulse during an active burst drops the old burst, and the next beat is the first beat of the new burst.
- R9: While clock enable is low, beat valid, the column and the last-beat flag hold their values. Start and stop requests sampled in those cycles have no effect.
- R10: A reserved length code (3'b100, 3'b101, 3'b110) gives a single-beat burst that carries the last-beat flag and sets the error flag. The error flag stays set until reset.
- R11: After reset, beat valid, last beat and the error flag are low and the column output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; low freezes all state |
| startPulse | input | 1 | Begin a new burst from startCol |
| stopPulse | input | 1 | Terminate the running burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | Beat order: 0 sequential, 1 interleaved |
| startCol | input | 8 | First column of the burst |
| beatValid | output | 1 | A beat is presented this cycle |
| beatCol | output | 8 | Column address of the current beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| lenError | output | 1 | Sticky: a reserved length code was started |

## Verification
The assertions check the timing rules on every cycle: the first beat appears one cycle after a start, the outputs hold while clock enable is low, beat valid drops after a last beat or a stop, full-page bursts never show a last beat, reserved codes give a flagged single beat, and the error flag never clears. The beat order inside the window cannot be checked by these properties. The sequential and interleaved orders, the pass-through of the upper bits, the wrap of a long full-page run and the exact beat count of each length are shown only by the bench scenarios, which compare every beat against a queue of independently computed columns.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to the next beat
  } ctrlStrobes_t;

  typedef struct packed {
    logic       full;      // full-page run
    logic       reserved;  // unsupported code, fall back to one beat
    logic [1:0] lenLog;    // log2 of fixed burst length
  } lenInfo_t;

  localparam logic [2:0] LEN_CODE_FULL = 3'b111;

  function automatic lenInfo_t decodeLen(input logic [2:0] code);
    lenInfo_t info;
    info = '0;
    if (code == LEN_CODE_FULL) begin
      info.full = 1'b1;
    end else if (code[2] == 1'b0) begin
      info.lenLog = code[1:0];
    end else begin
      info.reserved = 1'b1;
    end
    return info;
  endfunction

endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkEn,
  input  logic               startPulse,
  input  logic               stopPulse,
  input  logic [2:0]         lenCode,
  input  logic               interleave,
  input  logic [COL_W-1:0]   beatIdx,
  output ctrlStrobes_t       strobes,
  output logic [COL_W-1:0]   winMask,
  output logic               xorOrder,
  output logic               active,
  output logic               lastBeat,
  output logic               lenError
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  lenInfo_t         info;
  logic             activeQ;
  logic             fullQ;
  logic             errQ;
  logic [COL_W-1:0] limitQ;
  logic             lastHit;
  logic             loadNow;
  logic             endNow;

  assign info    = decodeLen(lenCode);
  assign winMask = info.full ? '1 : ((ONE << info.lenLog) - ONE);
  assign xorOrder = interleave && !info.full;

  assign lastHit = activeQ && !fullQ && (beatIdx == limitQ);
  assign loadNow = clkEn && startPulse;
  assign endNow  = stopPulse || lastHit;

  assign strobes.load = loadNow;
  assign strobes.step = clkEn && activeQ && !loadNow && !endNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      errQ    <= 1'b0;
      limitQ  <= '0;
    end else if (loadNow) begin
      activeQ <= 1'b1;
      fullQ   <= info.full;
      limitQ  <= winMask;
      errQ    <= errQ | info.reserved;
    end else if (clkEn && activeQ && endNow) begin
      activeQ <= 1'b0;
    end
  end

  assign active   = activeQ;
  assign lastBeat = lastHit;
  assign lenError = errQ;

endmodule

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [COL_W-1:0]   startCol,
  input  logic [COL_W-1:0]   winMask,
  input  logic               xorOrder,
  output logic [COL_W-1:0]   beatIdx,
  output logic [COL_W-1:0]   beatCol
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] cntQ;
  logic             xorQ;
  logic [COL_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      maskQ  <= '0;
      cntQ   <= '0;
      xorQ   <= 1'b0;
    end else if (strobes.load) begin
      startQ <= startCol;
      maskQ  <= winMask;
      xorQ   <= xorOrder;
      cntQ   <= '0;
    end else if (strobes.step) begin
      cntQ   <= cntQ + COL_W'(1);
    end
  end

  // Full page uses an all-ones mask, so the same merge covers every mode
  assign lowBits = xorQ ? (startQ ^ cntQ) : (startQ + cntQ);
  assign beatCol = (startQ & ~maskQ) | (lowBits & maskQ);
  assign beatIdx = cntQ;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic [COL_W-1:0] startCol,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             lastBeat,
  output logic             lenError
);

  ctrlStrobes_t     strobes;
  logic [COL_W-1:0] winMask;
  logic [COL_W-1:0] beatIdx;
  logic             xorOrder;

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .lenCode    (lenCode),
    .interleave (interleave),
    .beatIdx    (beatIdx),
    .strobes    (strobes),
    .winMask    (winMask),
    .xorOrder   (xorOrder),
    .active     (beatValid),
    .lastBeat   (lastBeat),
    .lenError   (lenError)
  );

  colgen_datapath #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startCol (startCol),
    .winMask  (winMask),
    .xorOrder (xorOrder),
    .beatIdx  (beatIdx),
    .beatCol  (beatCol)
  );

endmodule

// File: rtl/sdram_burst_colgen_checker.sv
module sdram_burst_colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             startPulse,
  input logic             stopPulse,
  input logic [2:0]       lenCode,
  input logic [COL_W-1:0] startCol,
  input logic             beatValid,
  input logic [COL_W-1:0] beatCol,
  input logic             lastBeat,
  input logic             lenError
);

  p_first_beat_r1: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && startPulse) |=> (beatValid && beatCol == $past(startCol)));

  p_full_no_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && startPulse && lenCode == 3'b111) |=> !lastBeat);

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && lastBeat && !startPulse) |=> !beatValid);

  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && stopPulse && !startPulse) |=> !beatValid);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(beatValid) && $stable(beatCol) && $stable(lastBeat)));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && startPulse && lenCode[2] && lenCode != 3'b111) |=> (lastBeat && lenError));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    lenError |=> lenError);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .lenCode    (lenCode),
  .startCol   (startCol),
  .beatValid  (beatValid),
  .beatCol    (beatCol),
  .lastBeat   (lastBeat),
  .lenError   (lenError)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       clkEn;
  logic       startPulse;
  logic       stopPulse;
  logic [2:0] lenCode;
  logic       interleave;
  logic [7:0] startCol;
  logic       beatValid;
  logic [7:0] beatCol;
  logic       lastBeat;
  logic       lenError;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } beat_t;

  beat_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen uut (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .lenCode    (lenCode),
    .interleave (interleave),
    .startCol   (startCol),
    .beatValid  (beatValid),
    .beatCol    (beatCol),
    .lastBeat   (lastBeat),
    .lenError   (lenError)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic int modelLen(input logic [2:0] code);
    if (code == 3'b111) return 0;
    if (code <= 3'd3)   return 1 << code;
    return 1;
  endfunction

  function automatic logic [7:0] modelCol(input logic [7:0] s, input logic [2:0] code,
                                          input bit il, input int i);
    logic [7:0] m;
    logic [7:0] low;
    if (code == 3'b111) return s + 8'(i);
    m   = 8'(modelLen(code) - 1);
    low = il ? (s ^ 8'(i)) : (s + 8'(i));
    return (s & ~m) | (low & m);
  endfunction

  // Driver: called at a falling edge; pushes the beats expected to appear
  task automatic startBurst(input logic [2:0] code, input bit il, input logic [7:0] col,
                            input int pushN, input string tag);
    beat_t b;
    startPulse = 1'b1;
    lenCode    = code;
    interleave = il;
    startCol   = col;
    for (int i = 0; i < pushN; i++) begin
      b.col  = modelCol(col, code, il, i);
      b.last = (code != 3'b111) && (i == modelLen(code) - 1);
      b.tag  = tag;
      expQ.push_back(b);
    end
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic stopNow();
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  task automatic idleCheck(input string tag);
    repeat (12) @(negedge clk);
    check(expQ.size() == 0, tag, "beats still owed", expQ.size(), 0);
    check(beatValid == 1'b0, tag, "valid after burst", int'(beatValid), 0);
  endtask

  // Monitor: pops and compares away from the clock edge
  initial begin
    logic [7:0] prevCol;
    logic       prevLast;
    logic       prevValid;
    beat_t      e;
    prevCol = '0; prevLast = 1'b0; prevValid = 1'b0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rstN === 1'b1) begin
        if (clkEn) begin
          if (beatValid) begin
            if (expQ.size() == 0) begin
              check(1'b0, "R6", "unexpected beat", int'(beatCol), 0);
            end else begin
              e = expQ.pop_front();
              check(beatCol == e.col, e.tag, "column", int'(beatCol), int'(e.col));
              check(lastBeat == e.last, e.tag, "last flag", int'(lastBeat), int'(e.last));
            end
          end
        end else begin
          // R9: frozen outputs
          check(beatValid == prevValid && beatCol == prevCol && lastBeat == prevLast,
                "R9", "frozen outputs moved", int'(beatCol), int'(prevCol));
        end
      end
      prevCol = beatCol; prevLast = lastBeat; prevValid = beatValid;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkEn = 1'b1; startPulse = 1'b0; stopPulse = 1'b0;
    lenCode = 3'b000; interleave = 1'b0; startCol = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(beatValid == 1'b0, "R11", "reset valid", int'(beatValid), 0);
    check(lastBeat  == 1'b0, "R11", "reset last", int'(lastBeat), 0);
    check(lenError  == 1'b0, "R11", "reset error", int'(lenError), 0);
    check(beatCol   == 8'h00, "R11", "reset column", int'(beatCol), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3: sequential 8-beat from 5 -> 5,6,7,0,1,2,3,4
    startBurst(3'b011, 1'b0, 8'h05, 8, "R3");
    idleCheck("R3");
    // R4: interleaved 8-beat from 5 -> 5,4,7,6,1,0,3,2
    startBurst(3'b011, 1'b1, 8'h05, 8, "R4");
    idleCheck("R4");
    // R3: upper bits kept, 4 beats from 2E -> 2E,2F,2C,2D
    startBurst(3'b010, 1'b0, 8'h2E, 4, "R3");
    idleCheck("R3");
    // R4: 4 beats from 2D -> 2D,2C,2F,2E
    startBurst(3'b010, 1'b1, 8'h2D, 4, "R4");
    idleCheck("R4");
    // R2: length 1 and 2
    startBurst(3'b000, 1'b0, 8'h77, 1, "R2");
    idleCheck("R2");
    startBurst(3'b001, 1'b1, 8'h33, 2, "R2");
    idleCheck("R2");

    // R5: full page with interleave high still counts up, FD..02, then stop
    startBurst(3'b111, 1'b1, 8'hFD, 6, "R5");
    repeat (5) @(negedge clk);
    stopNow();
    idleCheck("R7");
    // R5: long full-page run through the page wrap
    startBurst(3'b111, 1'b0, 8'h00, 260, "R5");
    repeat (259) @(negedge clk);
    stopNow();
    idleCheck("R5");

    // R7: stop a fixed burst after 3 beats
    startBurst(3'b011, 1'b0, 8'h40, 3, "R7");
    repeat (2) @(negedge clk);
    stopNow();
    idleCheck("R7");

    // R8: restart after 2 beats with an interleaved 4-beat burst from 43
    startBurst(3'b011, 1'b0, 8'h10, 2, "R8");
    repeat (1) @(negedge clk);
    startBurst(3'b010, 1'b1, 8'h43, 4, "R8");
    idleCheck("R8");

    // R9: freeze mid-burst; stop and start while frozen are ignored
    startBurst(3'b010, 1'b0, 8'h08, 4, "R9");
    clkEn = 1'b0; stopPulse = 1'b1; startPulse = 1'b1; startCol = 8'hAA;
    repeat (3) @(negedge clk);
    clkEn = 1'b1; stopPulse = 1'b0; startPulse = 1'b0;
    idleCheck("R9");

    // R10: reserved code gives one flagged beat and a sticky error
    check(lenError == 1'b0, "R10", "error before reserved", int'(lenError), 0);
    startBurst(3'b101, 1'b0, 8'h9C, 1, "R10");
    idleCheck("R10");
    check(lenError == 1'b1, "R10", "error after reserved", int'(lenError), 1);
    startBurst(3'b010, 1'b0, 8'h00, 4, "R10");
    idleCheck("R10");
    check(lenError == 1'b1, "R10", "error sticky", int'(lenError), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule